// File: doc/BRIEF.md
# Four-Phase Handshake Bus Master

This block is the host side of a parallel asynchronous bus. It runs single read and write transactions against an external slave. The bus carries an 8-bit address and a 32-bit data path, which is split into output, input and output-enable for the pad ring. Three active-low strobes control it: read select, write select and chip enable. The slave answers on an active-low ready line. It also raises a booted line once it can take traffic.

On the user side, a request is presented with its direction, address and write data. The block captures these fields and sets up the bus one cycle before chip enable falls. It then waits for the synchronized ready to go low and answers the user with a one-cycle acknowledge. For reads, the acknowledge carries the captured data. The block then releases all strobes and waits until ready has gone high again, so that all four phases of the handshake complete before the next transfer. If ready does not arrive within a configurable number of cycles, the transfer is aborted and flagged with an error.

Top module: `hbm_bus_master`

## Requirements
- R1: While rst_ni is low, bus_ce_no, bus_rd_no and bus_wr_no are 1, and bus_data_oe_o, ack_o and err_o are 0.
- R2: No transfer starts while slave_booted_i (after its two-flop synchronizer) is low. A request held during that time starts once booted is seen high.
- R3: Address and direction select are driven at least one cycle before bus_ce_no falls. The address stays stable while bus_ce_no is low.
- R4: While bus_ce_no is low, exactly one of bus_rd_no and bus_wr_no is low. bus_rd_no low means read and bus_wr_no low means write; req_we_i=1 selects a write.
- R5: During a write, bus_data_oe_o is 1 and bus_data_o equals the captured req_wdata_i. During a read, bus_data_oe_o is never 1.
- R6: A read returns on rdata_o the value on bus_data_i in the cycle where synchronized ready is first seen low. rdata_o is valid while ack_o is high.
- R7: In the cycle ack_o is high, all three strobes are already back at 1 and bus_data_oe_o is 0.
- R8: After a transfer, no new transfer begins (both select lines stay high) until synchronized ready has returned high.
- R9: If synchronized ready is not seen low within TIMEOUT_CYC cycles of chip enable falling, the strobes are deasserted and ack_o pulses together with err_o=1. Otherwise err_o=0 with ack_o.
- R10: ack_o is a single-cycle pulse per transfer, and err_o is only ever high together with ack_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, held until ack_o |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Transfer address |
| req_wdata_i | input | 32 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with ack_o |
| rdata_o | output | 32 | Read data, valid with ack_o |
| bus_addr_o | output | 8 | Bus address |
| bus_data_o | output | 32 | Bus data driven by the master |
| bus_data_oe_o | output | 1 | Output enable for bus_data_o |
| bus_data_i | input | 32 | Bus data seen at the pads |
| bus_rd_no | output | 1 | Read select, active low |
| bus_wr_no | output | 1 | Write select, active low |
| bus_ce_no | output | 1 | Chip enable, active low |
| bus_rdy_ni | input | 1 | Slave ready, active low, asynchronous |
| slave_booted_i | input | 1 | Slave ready for traffic, asynchronous |

## Verification
A controller stuck in its release phase shows as a request that is never started. This is visible at the ports within a few cycles of the slave raising ready. A controller that leaves release too early shows as a select line falling while the slave still holds ready low. A wrong direction or address register shows at the first chip-enable fall, because the slave model records both the bus address and the select lines there. A broken timeout counter shows as either a missing acknowledge or an error on a transfer that did complete, one timeout window after chip enable falls.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_WAIT    = 2'd2,
    ST_RELEASE = 2'd3
  } hbm_state_e;
endpackage

// File: rtl/hbm_sync.sv
module hbm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/hbm_timer.sv
module hbm_timer #(
  parameter int LIMIT = 64,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;

  assign expired_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/hbm_bus_master.sv
module hbm_bus_master #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              bus_rd_no,
  output logic              bus_wr_no,
  output logic              bus_ce_no,
  input  logic              bus_rdy_ni,
  input  logic              slave_booted_i
);
  import hbm_pkg::*;

  hbm_state_e        state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              ack_q, err_q;
  logic              rdy_n_sync, booted_sync, expired;
  logic              start, done_ok, done_to, active;

  hbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rdy (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_rdy_ni), .q_o(rdy_n_sync));

  hbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_boot (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(slave_booted_i), .q_o(booted_sync));

  hbm_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q == ST_WAIT), .expired_o(expired));

  assign start   = (state_q == ST_IDLE) && req_i && booted_sync && rdy_n_sync;
  assign done_ok = (state_q == ST_WAIT) && !rdy_n_sync;
  assign done_to = (state_q == ST_WAIT) && rdy_n_sync && expired;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_SETUP;
      ST_SETUP:   state_d = ST_WAIT;
      ST_WAIT:    if (done_ok || done_to) state_d = ST_RELEASE;
      ST_RELEASE: if (rdy_n_sync) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  // request fields captured once, held for the whole transfer
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      we_q    <= req_we_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rdata_q <= '0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ack_q <= done_ok || done_to;
      err_q <= done_to;
      if (done_ok && !we_q) rdata_q <= bus_data_i;
    end

  assign active        = (state_q == ST_SETUP) || (state_q == ST_WAIT);
  assign bus_ce_no     = (state_q != ST_WAIT);
  assign bus_rd_no     = !(active && !we_q);
  assign bus_wr_no     = !(active && we_q);
  assign bus_data_oe_o = active && we_q;
  assign bus_data_o    = wdata_q;
  assign bus_addr_o    = addr_q;
  assign ack_o         = ack_q;
  assign err_o         = err_q;
  assign rdata_o       = rdata_q;
endmodule

// File: rtl/hbm_bus_master_chk.sv
module hbm_bus_master_chk (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_o,
  input logic               err_o,
  input logic [7:0]         bus_addr_o,
  input logic               bus_data_oe_o,
  input logic               bus_rd_no,
  input logic               bus_wr_no,
  input logic               bus_ce_no,
  input logic               rdy_n_sync,
  input logic               booted_sync,
  input hbm_pkg::hbm_state_e state_q
);
  import hbm_pkg::*;

  // R1
  always @(posedge clk_i)
    if (!rst_ni)
      reset_idle_chk: assert (bus_ce_no && bus_rd_no && bus_wr_no && !bus_data_oe_o && !ack_o && !err_o);

  // R2
  boot_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !booted_sync) |=> state_q == ST_IDLE);

  // R3
  ce_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ce_no) |-> ($stable(bus_addr_o) && $stable(bus_rd_no) && $stable(bus_wr_no)));

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ce_no && !$past(bus_ce_no)) |-> $stable(bus_addr_o));

  // R4
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_ce_no |-> (bus_rd_no != bus_wr_no));

  // R5
  oe_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> (!bus_wr_no && bus_rd_no));

  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (bus_ce_no && bus_rd_no && bus_wr_no && !bus_data_oe_o));

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RELEASE && !rdy_n_sync) |=> (bus_rd_no && bus_wr_no));

  // R10
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R10
  err_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ack_o);
endmodule

bind hbm_bus_master hbm_bus_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .err_o(err_o),
  .bus_addr_o(bus_addr_o), .bus_data_oe_o(bus_data_oe_o),
  .bus_rd_no(bus_rd_no), .bus_wr_no(bus_wr_no), .bus_ce_no(bus_ce_no),
  .rdy_n_sync(rdy_n_sync), .booted_sync(booted_sync), .state_q(state_q));

// File: tb/hbm_bus_master_tb_top.sv
`timescale 1ns/1ps
module hbm_bus_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        ack_o, err_o, bus_data_oe_o, bus_rd_no, bus_wr_no, bus_ce_no;
  logic [31:0] rdata_o, bus_data_o;
  logic [7:0]  bus_addr_o;
  logic [31:0] data_in = 32'hA5A5_5A5A;
  logic        rdy_n = 1'b1, booted = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hbm_bus_master dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ack_o(ack_o), .err_o(err_o),
    .rdata_o(rdata_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
    .bus_data_oe_o(bus_data_oe_o), .bus_data_i(data_in), .bus_rd_no(bus_rd_no),
    .bus_wr_no(bus_wr_no), .bus_ce_no(bus_ce_no), .bus_rdy_ni(rdy_n),
    .slave_booted_i(booted));

  // slave model
  int          s_st = 0, s_cnt = 0, s_hc = 0, s_delay = 2, s_hold = 1;
  bit          s_mute = 0;
  logic [31:0] s_rdval = '0, s_wdata = '0;
  logic [7:0]  s_addr_ce = '0, s_addr = '0;
  logic        s_oe = 0, s_we = 0, s_dir_ce = 0;

  always @(negedge clk) begin
    case (s_st)
      0: if (!bus_ce_no) begin
           s_cnt = 0; s_addr_ce = bus_addr_o; s_dir_ce = !bus_wr_no && bus_rd_no; s_st = 1;
         end
      1: if (bus_ce_no) s_st = 0;
         else if (!s_mute && s_cnt >= s_delay) begin
           rdy_n = 1'b0;
           if (!bus_rd_no) data_in = s_rdval;
           s_addr = bus_addr_o; s_wdata = bus_data_o; s_oe = bus_data_oe_o; s_we = !bus_wr_no;
           s_hc = 0; s_st = 2;
         end else s_cnt++;
      2: if (bus_ce_no && bus_rd_no && bus_wr_no) begin
           if (s_hc >= s_hold) begin rdy_n = 1'b1; data_in = 32'hA5A5_5A5A; s_st = 0; end
           else s_hc++;
         end
      default: s_st = 0;
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        x_ack, x_err, x_rel, x_ack_next;
  logic [31:0] x_rdata;

  task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d);
    int n = 0;
    @(negedge clk);
    req_we = we; req_addr = a; req_wdata = d; req = 1'b1;
    @(negedge clk);
    while (!ack_o && n < 2000) begin @(negedge clk); n++; end
    x_ack = ack_o; x_err = err_o; x_rdata = rdata_o;
    x_rel = bus_ce_no && bus_rd_no && bus_wr_no && !bus_data_oe_o;
    req = 1'b0;
    @(negedge clk);
    x_ack_next = ack_o;
  endtask

  task automatic settle();
    while (s_st != 0 || !rdy_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // {we, addr, data, slave delay}
  localparam logic [48:0] VEC [6] = '{
    {1'b1, 8'h00, 32'h0000_0000, 8'd0},
    {1'b0, 8'hFF, 32'hDEAD_BEEF, 8'd0},
    {1'b1, 8'h5A, 32'hFFFF_FFFF, 8'd3},
    {1'b0, 8'hA5, 32'h1234_5678, 8'd7},
    {1'b1, 8'h81, 32'h8000_0001, 8'd12},
    {1'b0, 8'h3C, 32'h0000_0000, 8'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 strobes", {29'd0, bus_ce_no, bus_rd_no, bus_wr_no}, 32'd7);
    chk("R1 oe/ack/err", {29'd0, bus_data_oe_o, ack_o, err_o}, 32'd0);
    rst_ni = 1'b1;

    // R2: request held while slave not booted
    @(negedge clk);
    req_we = 1'b0; req_addr = 8'h11; req = 1'b1; s_rdval = 32'hCAFE_0011;
    begin
      bit moved = 0;
      repeat (20) begin @(negedge clk); if (!bus_rd_no || !bus_wr_no || !bus_ce_no) moved = 1; end
      chk("R2 no start before boot", {31'd0, moved}, 32'd0);
    end
    booted = 1'b1;
    begin
      int n = 0;
      while (!ack_o && n < 200) begin @(negedge clk); n++; end
      chk("R2 starts after boot", {31'd0, ack_o}, 32'd1);
      chk("R6 read after boot", rdata_o, 32'hCAFE_0011);
      req = 1'b0;
    end
    settle();

    foreach (VEC[i]) begin
      logic        we = VEC[i][48];
      logic [7:0]  a  = VEC[i][47:40];
      logic [31:0] d  = VEC[i][39:8];
      s_delay = int'(VEC[i][7:0]);
      s_rdval = d;
      xfer(we, a, d);
      chk($sformatf("R10 ack vec%0d", i), {31'd0, x_ack}, 32'd1);
      chk($sformatf("R10 ack pulse vec%0d", i), {31'd0, x_ack_next}, 32'd0);
      chk($sformatf("R9 no err vec%0d", i), {31'd0, x_err}, 32'd0);
      chk($sformatf("R7 released vec%0d", i), {31'd0, x_rel}, 32'd1);
      chk($sformatf("R3 addr at ce vec%0d", i), {24'd0, s_addr_ce}, {24'd0, a});
      chk($sformatf("R4 dir at ce vec%0d", i), {31'd0, s_dir_ce}, {31'd0, we});
      chk($sformatf("R3 addr at rdy vec%0d", i), {24'd0, s_addr}, {24'd0, a});
      chk($sformatf("R5 oe vec%0d", i), {31'd0, s_oe}, {31'd0, we});
      if (we) chk($sformatf("R5 wdata vec%0d", i), s_wdata, d);
      else    chk($sformatf("R6 rdata vec%0d", i), x_rdata, d);
      settle();
    end

    // R8: slave holds ready low long after strobes release
    s_delay = 1; s_hold = 20; s_rdval = 32'h0BAD_F00D;
    xfer(1'b0, 8'h42, 32'd0);
    chk("R8 first read", x_rdata, 32'h0BAD_F00D);
    req_we = 1'b1; req_addr = 8'h43; req_wdata = 32'h7777_0000; req = 1'b1;
    begin
      bit early = 0;
      repeat (15) begin @(negedge clk); if (!bus_rd_no || !bus_wr_no) early = 1; end
      chk("R8 no restart while ready low", {31'd0, early}, 32'd0);
    end
    begin
      int n = 0;
      while (!ack_o && n < 200) begin @(negedge clk); n++; end
      chk("R8 second xfer completes", {31'd0, ack_o}, 32'd1);
      req = 1'b0;
    end
    chk("R8 second write data", s_wdata, 32'h7777_0000);
    s_hold = 1;
    settle();

    // R9: slave never answers
    s_mute = 1;
    xfer(1'b1, 8'h99, 32'h5555_AAAA);
    chk("R9 timeout ack", {31'd0, x_ack}, 32'd1);
    chk("R9 timeout err", {31'd0, x_err}, 32'd1);
    chk("R9 strobes released", {31'd0, x_rel}, 32'd1);
    s_mute = 0;
    settle();
    s_delay = 2; s_rdval = 32'h2468_ACE0;
    xfer(1'b0, 8'h9A, 32'd0);
    chk("R9 recovery no err", {31'd0, x_err}, 32'd0);
    chk("R9 recovery rdata", x_rdata, 32'h2468_ACE0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (R1..) actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule